// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block derives the serial bit clock of an SPI controller from a faster source clock. The divide ratio comes from one of two arithmetic paths. The power-of-two path divides the source by four and then by two raised to a 3-bit exponent. The linear path divides by two and then by an 8-bit value plus one. A select bit in the linear-path control word picks the path. A build parameter can remove the linear path and the selector, so that only the power-of-two path remains.

A small state machine with three states produces the output. The states are LOAD, LOW and HIGH. LOAD is entered on reset, and its only transition goes to LOW. That transition captures the active half-period. The LOW-to-HIGH transition happens when the phase counter reaches the captured terminal count. The HIGH-to-LOW transition happens at the same terminal count and also captures a fresh half-period from the control words. Because of this, a new ratio or path only takes hold at the start of a low phase, and no shortened pulse can appear. Both halves of every period have the same length, so the duty cycle is exactly 50%. A one-cycle tick marks every level change of the output.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is active, `sclk_out` and `edge_tick` are 0 and the phase counter is cleared. After release, one LOAD cycle is followed by a full low phase, so with both words zero the first rising edge is seen 3 source cycles after release.
- R2: With bit 24 of `enhanced_ctrl` at 0, the output period is 4·2^E source cycles, where E is `legacy_ctrl[18:16]`.
- R3: Every high phase and every low phase is exactly half of the selected period (50% duty).
- R4: With bit 24 of `enhanced_ctrl` at 1, the output period is 2·(D+1) source cycles, where D is `enhanced_ctrl[23:16]`.
- R5: `edge_tick` is 1 in exactly those cycles in which `sclk_out` holds a level different from the previous cycle.
- R6: A change of E, D or the select bit leaves the phase in progress unaffected. If the change arrives during a low phase, the following high phase is unaffected too. The new value applies from the next falling edge of `sclk_out` onward.
- R7: With `ENH_PRESENT` = 0, bit 24 and D are ignored and the period is always 4·2^E.
- R8: Bits of both control words outside 18:16 of `legacy_ctrl`, and outside 23:16 and 24 of `enhanced_ctrl`, have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_ctrl | input | 32 | Power-of-two path control word, exponent E at bits 18:16 |
| enhanced_ctrl | input | 32 | Linear path control word, divisor D at bits 23:16, path select at bit 24 |
| sclk_out | output | 1 | Serial bit clock, 50% duty |
| edge_tick | output | 1 | One-cycle pulse on every level change of sclk_out |

## Verification
Two functions can land on the same clock edge: a control-word update, and the HIGH-to-LOW terminal count that captures the configuration. The bench provokes the overlap by rewriting the divisor partway through a high phase, and by switching the path select partway through a low phase. It then measures the length of each following phase in source cycles. The design passes only if the phase in progress (and, for a low-phase change, the high phase after it) keeps the old length, and the new length first appears in the low phase that starts at the next falling edge.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/sclk_pow2_term.sv
// Power-of-two path: half period = 2 * 2^E source cycles, terminal = 2^(E+1) - 1.
module sclk_pow2_term #(
    parameter int EXP_W = 3,
    parameter int CNT_W = 8
) (
    input  logic [EXP_W-1:0] exp_i,
    output logic [CNT_W-1:0] term_o
);
    logic [EXP_W:0] shamt;
    logic [CNT_W:0] pow;

    always_comb begin
        shamt  = {1'b0, exp_i} + 1'b1;
        pow    = (CNT_W+1)'(1) << shamt;
        term_o = CNT_W'(pow - 1'b1);
    end
endmodule

// File: rtl/sclk_linear_term.sv
// Linear path: half period = D + 1 source cycles, terminal = D.
module sclk_linear_term #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] term_o
);
    always_comb begin
        term_o = CNT_W'(div_i);
    end
endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import spi_sclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_term,
    output logic             sclk,
    output logic             tick
);
    phase_e           phase_q, phase_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] term_q, term_nx;
    logic             tick_q, tick_nx;
    logic             at_term;

    assign at_term = (cnt_q == term_q);

    always_comb begin
        phase_nx = phase_q;
        cnt_nx   = cnt_q + 1'b1;
        term_nx  = term_q;
        tick_nx  = 1'b0;
        unique case (phase_q)
            PH_LOAD: begin
                phase_nx = PH_LOW;
                cnt_nx   = '0;
                term_nx  = next_term;
            end
            PH_LOW: begin
                if (at_term) begin
                    phase_nx = PH_HIGH;
                    cnt_nx   = '0;
                    tick_nx  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (at_term) begin
                    phase_nx = PH_LOW;
                    cnt_nx   = '0;
                    tick_nx  = 1'b1;
                    term_nx  = next_term;
                end
            end
            default: begin
                phase_nx = PH_LOAD;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
            term_q  <= '0;
            tick_q  <= 1'b0;
        end else begin
            phase_q <= phase_nx;
            cnt_q   <= cnt_nx;
            term_q  <= term_nx;
            tick_q  <= tick_nx;
        end
    end

    always_comb begin
        sclk = (phase_q == PH_HIGH);
        tick = tick_q;
    end

    assert_tick_marks_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick == (sclk != $past(sclk)));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term_q);

    assert_flip_at_terminal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ($past(cnt_q) == $past(term_q)));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(term_q) |-> ((phase_q == PH_LOW) && (tick || $past(phase_q) == PH_LOAD)));
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
    parameter int CTRL_W      = 32,
    parameter int LEG_EXP_W   = 3,
    parameter int LEG_EXP_LSB = 16,
    parameter int ENH_DIV_W   = 8,
    parameter int ENH_DIV_LSB = 16,
    parameter int ENH_SEL_POS = 24,
    parameter bit ENH_PRESENT = 1'b1
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] legacy_ctrl,
    input  logic [CTRL_W-1:0] enhanced_ctrl,
    output logic              sclk_out,
    output logic              edge_tick
);
    localparam int LEG_CNT_W = 1 << LEG_EXP_W;
    localparam int CNT_W     = (LEG_CNT_W > ENH_DIV_W) ? LEG_CNT_W : ENH_DIV_W;

    logic [CNT_W-1:0] leg_term;
    logic [CNT_W-1:0] next_term;
    logic             ctrl_unused;

    assign ctrl_unused = ^{legacy_ctrl, enhanced_ctrl};

    sclk_pow2_term #(.EXP_W(LEG_EXP_W), .CNT_W(CNT_W)) u_pow2 (
        .exp_i  (legacy_ctrl[LEG_EXP_LSB +: LEG_EXP_W]),
        .term_o (leg_term)
    );

    if (ENH_PRESENT) begin : g_dual
        logic [CNT_W-1:0] lin_term;
        sclk_linear_term #(.DIV_W(ENH_DIV_W), .CNT_W(CNT_W)) u_linear (
            .div_i  (enhanced_ctrl[ENH_DIV_LSB +: ENH_DIV_W]),
            .term_o (lin_term)
        );
        assign next_term = enhanced_ctrl[ENH_SEL_POS] ? lin_term : leg_term;
    end else begin : g_single
        assign next_term = leg_term;
    end

    sclk_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .next_term (next_term),
        .sclk      (sclk_out),
        .tick      (edge_tick)
    );
endmodule

// File: tb/test_spi_sclk_divider.sv
`timescale 1ns/1ps
module test_spi_sclk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] leg_w = '0;
    logic [31:0] enh_w = '0;
    logic        sclk0, tick0, sclk1, tick1;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int          tmis0 = 0, tmis1 = 0;
    logic        prev0 = 1'b0, prev1 = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sclk_divider i_spi_sclk_divider (
        .clk_src(clk), .rst_n(rst_n), .legacy_ctrl(leg_w), .enhanced_ctrl(enh_w),
        .sclk_out(sclk0), .edge_tick(tick0));

    spi_sclk_divider #(.ENH_PRESENT(1'b0)) i_spi_sclk_divider_leg (
        .clk_src(clk), .rst_n(rst_n), .legacy_ctrl(leg_w), .enhanced_ctrl(enh_w),
        .sclk_out(sclk1), .edge_tick(tick1));

    // R5 monitor: tick must match a level change since the previous sample
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick0 != (sclk0 != prev0)) tmis0 <= tmis0 + 1;
            if (tick1 != (sclk1 != prev1)) tmis1 <= tmis1 + 1;
        end
        prev0 <= sclk0;
        prev1 <= sclk1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic get_sclk(input int which);
        return (which == 0) ? sclk0 : sclk1;
    endfunction

    function automatic logic get_tick(input int which);
        return (which == 0) ? tick0 : tick1;
    endfunction

    task automatic wait_edge(input int which, input logic lvl, output int when);
        when = -1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (get_tick(which) && get_sclk(which) == lvl) begin
                when = cyc;
                break;
            end
        end
    endtask

    task automatic write_cfg(input logic [31:0] lw, input logic [31:0] ew);
        #1;
        leg_w = lw;
        enh_w = ew;
    endtask

    task automatic measure(input int which, input int half, input string req);
        int tf, t0, t1, t2;
        wait_edge(which, 1'b0, tf);
        wait_edge(which, 1'b1, t0);
        wait_edge(which, 1'b0, t1);
        wait_edge(which, 1'b1, t2);
        check(t1 - t0 == half, {req, " high phase (R3)"}, t1 - t0, half);
        check(t2 - t1 == half, {req, " low phase (R3)"}, t2 - t1, half);
        check(t2 - t0 == 2 * half, {req, " period"}, t2 - t0, 2 * half);
    endtask

    task automatic test_reset_r1;
        int t0, t1, rel;
        repeat (3) @(negedge clk);
        check(sclk0 == 1'b0 && tick0 == 1'b0, "R1 reset level", sclk0, 0);
        check(sclk1 == 1'b0 && tick1 == 1'b0, "R1 reset level legacy-only", sclk1, 0);
        #1 rst_n = 1'b1;
        rel = cyc;
        wait_edge(0, 1'b1, t0);
        check(t0 - rel == 3, "R1 first rise after release", t0 - rel, 3);
        // mid-run reset during a long high phase
        write_cfg(32'h0007_0000, 32'h0000_0000);
        wait_edge(0, 1'b1, t0);
        wait_edge(0, 1'b1, t0);
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check(sclk0 == 1'b0, "R1 output low in reset", sclk0, 0);
        write_cfg(32'h0, 32'h0);
        #1 rst_n = 1'b1;
        rel = cyc;
        wait_edge(1, 1'b1, t1);
        check(t1 - rel == 3, "R1 counter cleared after reset", t1 - rel, 3);
    endtask

    task automatic test_pow2_r2;
        write_cfg(32'h0000_0000, 32'h0000_0000);
        measure(0, 2, "R2 E=0");
        write_cfg(32'h0003_0000, 32'h0000_0000);
        measure(0, 16, "R2 E=3");
        write_cfg(32'h0007_0000, 32'h0000_0000);
        measure(0, 256, "R2 E=7");
    endtask

    task automatic test_linear_r4;
        write_cfg(32'h0000_0000, 32'h0100_0000);
        measure(0, 1, "R4 D=0");
        write_cfg(32'h0000_0000, 32'h0164_0000);
        measure(0, 101, "R4 D=100");
        write_cfg(32'h0000_0000, 32'h01FF_0000);
        measure(0, 256, "R4 D=255");
    endtask

    task automatic test_other_bits_r8;
        write_cfg(32'hFFFA_FFFF, 32'hFE5A_FFFF);
        measure(0, 8, "R8 stray bits, pow2 E=2");
        write_cfg(32'hFFFA_FFFF, 32'hFF04_FFFF);
        measure(0, 5, "R8 stray bits, linear D=4");
    endtask

    task automatic test_change_r6;
        int t0, t1, t2, t3;
        write_cfg(32'h0000_0000, 32'h0109_0000);
        measure(0, 10, "R6 setup D=9");
        wait_edge(0, 1'b1, t0);
        repeat (2) @(negedge clk);
        write_cfg(32'h0000_0000, 32'h0101_0000);
        wait_edge(0, 1'b0, t1);
        wait_edge(0, 1'b1, t2);
        check(t1 - t0 == 10, "R6 high phase keeps old divisor", t1 - t0, 10);
        check(t2 - t1 == 2, "R6 new divisor from falling edge", t2 - t1, 2);
        wait_edge(0, 1'b0, t0);
        write_cfg(32'h0003_0000, 32'h0001_0000);
        wait_edge(0, 1'b1, t1);
        wait_edge(0, 1'b0, t2);
        wait_edge(0, 1'b1, t3);
        check(t1 - t0 == 2, "R6 low phase keeps old path", t1 - t0, 2);
        check(t2 - t1 == 2, "R6 next high keeps old path", t2 - t1, 2);
        check(t3 - t2 == 16, "R6 select applies from falling edge", t3 - t2, 16);
    endtask

    task automatic test_single_path_r7;
        write_cfg(32'h0001_0000, 32'h0100_0000);
        measure(1, 4, "R7 select ignored, E=1");
        write_cfg(32'h0004_0000, 32'h01FF_0000);
        measure(1, 32, "R7 divisor ignored, E=4");
        measure(0, 256, "R4 dual build same words");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset_r1();
        test_pow2_r2();
        test_linear_r4();
        test_other_bits_r8();
        test_change_r6();
        test_single_path_r7();
        @(negedge clk);
        check(tmis0 == 0, "R5 tick matches edges (dual)", tmis0, 0);
        check(tmis1 == 0, "R5 tick matches edges (single)", tmis1, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule